// File: doc/BRIEF.md
# ADC conversion sequencer controller

This block is the digital controller that decides which analog channel a multi-channel converter samples next. It keeps two programmed channel lists: a regular list of up to sixteen entries and a priority (injected) list of up to four entries. A start request for either list makes the block walk that list through a start/done handshake with the converter. It stores each returned result and raises end-of-sequence flags and interrupts. Every result is also compared against a programmable analog watchdog window.

All control bits are plain input ports. Scan mode selects between converting the whole list and converting only its first entry. Each list has its own discontinuous mode, which converts a short burst per request and resumes where the previous burst stopped. An automatic mode chains the injected list after every completed regular sequence. A watchdog trip can abort the running sequence when the watchdog interrupt is enabled.

The injected list takes priority at conversion boundaries: a pending injected request is served before the next regular conversion, and the regular sequence then resumes. A request that arrives while its list is busy is kept and served afterwards.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `conv_start`, `busy`, all three flags and all three interrupt outputs are 0.
- R2: With `scan_en` = 0 and discontinuous mode off, a request converts only entry 0 of its list (entry k of a list sits at bits [5k+4:5k]) and then ends the sequence.
- R3: With `scan_en` = 1 and discontinuous mode off, a request converts entries 0 to L-1 in order, where L is the length port value plus one.
- R4: `eoc_flag` (regular) and `jeoc_flag` (injected) are set only when the conversion of the last entry of the list completes, never after an earlier entry of a scan.
- R5: `eoc_irq`, `jeoc_irq` and `wdg_irq` are 1 exactly when the matching flag is set and the matching enable input is 1.
- R6: A regular result is written to `reg_data`; an injected result for list entry k is written to slot k of `inj_data`, bits [12k+11:12k].
- R7: With `auto_inj_en` = 1, completion of a regular sequence starts the injected list with no injected request.
- R8: With `reg_disc_en` = 1, each regular request converts the next `disc_cnt`+1 entries, wrapping from the last entry to entry 0. `eoc_flag` is set when the last entry completes. Any sequence that is not discontinuous, and any abort, returns the position to entry 0.
- R9: With `inj_disc_en` = 1, each injected request converts exactly one injected entry. Each discontinuous bit acts on its own list only.
- R10: `wdg_flag` is set when a result is below `wdg_low` or above `wdg_high`, on every channel when `wdg_single` = 0, and only for results of channel `wdg_chan` when `wdg_single` = 1.
- R11: A watchdog trip with `wdg_int_en` = 1 ends the running sequence at once without setting its end flag. With `wdg_int_en` = 0 the sequence runs to its end.
- R12: Each flag stays set until its clear input is pulsed; a clear pulse affects only its own flag.
- R13: A request that arrives while the block is busy is never lost. An injected request made during a regular scan is served at the next conversion boundary, and the regular scan then continues.
- R14: `conv_start` is a one-cycle pulse, at most one conversion is outstanding, and `conv_chan` stays stable until `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_start | input | 1 | Regular list start request pulse |
| inj_start | input | 1 | Injected list start request pulse |
| scan_en | input | 1 | 1: convert whole list, 0: first entry only |
| reg_disc_en | input | 1 | Discontinuous mode for the regular list |
| inj_disc_en | input | 1 | Discontinuous mode for the injected list |
| disc_cnt | input | 3 | Regular burst length minus one |
| auto_inj_en | input | 1 | Chain injected list after each regular sequence |
| reg_len | input | 4 | Regular list length minus one |
| inj_len | input | 2 | Injected list length minus one |
| reg_list | input | 80 | Regular channel list, 5 bits per entry |
| inj_list | input | 20 | Injected channel list, 5 bits per entry |
| wdg_single | input | 1 | Watchdog watches one channel only |
| wdg_chan | input | 5 | Channel watched when wdg_single is 1 |
| wdg_low | input | 12 | Watchdog low threshold |
| wdg_high | input | 12 | Watchdog high threshold |
| wdg_int_en | input | 1 | Watchdog interrupt enable, also enables abort |
| eoc_int_en | input | 1 | Regular end interrupt enable |
| jeoc_int_en | input | 1 | Injected end interrupt enable |
| eoc_clr | input | 1 | Clear pulse for eoc_flag |
| jeoc_clr | input | 1 | Clear pulse for jeoc_flag |
| wdg_clr | input | 1 | Clear pulse for wdg_flag |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 5 | Channel for the current conversion |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 12 | Converter result, valid with conv_done |
| reg_data | output | 12 | Last regular result |
| inj_data | output | 48 | Injected results, one 12-bit slot per entry |
| eoc_flag | output | 1 | Regular sequence end flag |
| jeoc_flag | output | 1 | Injected sequence end flag |
| wdg_flag | output | 1 | Watchdog window flag |
| eoc_irq | output | 1 | Regular end interrupt |
| jeoc_irq | output | 1 | Injected end interrupt |
| wdg_irq | output | 1 | Watchdog interrupt |
| busy | output | 1 | Any request pending, list active or conversion outstanding |

## Verification
The bench builds the block with its default parameters: a sixteen-entry regular list, a four-entry injected list, 5-bit channels, 12-bit results and a 3-bit burst count. At these sizes a random regular length of 1 to 16 covers both the single-entry list and the full list. A seven-entry list with a three-conversion burst makes the position wrap inside one discontinuous burst. The four injected slots are each written and read back, and a converter model with a fixed latency lets injected requests land in the middle of a regular scan.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic {
      GRP_REG = 1'b0,
      GRP_INJ = 1'b1
   } grp_e;

   function automatic int idx_w(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/adc_seq_group.sv
module adc_seq_group
   import adc_seq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int CH_W     = 5,
   parameter int DATA_W   = 12,
   parameter int DISC_W   = 3,
   parameter bit PER_RANK = 1'b0,
   localparam int IDX_W   = idx_w(DEPTH),
   localparam int NSLOT   = PER_RANK ? DEPTH : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DEPTH*CH_W-1:0]   list,
   input  logic [IDX_W-1:0]        len_m1,
   input  logic                    scan_en,
   input  logic                    disc_en,
   input  logic [DISC_W-1:0]       disc_m1,
   input  logic                    req_i,
   input  logic                    begin_i,
   input  logic                    done_i,
   input  logic                    abort_i,
   input  logic [DATA_W-1:0]       res_i,
   output logic                    pend_o,
   output logic                    active_o,
   output logic [CH_W-1:0]         chan_o,
   output logic                    seq_end_o,
   output logic [NSLOT*DATA_W-1:0] res_o
);

   localparam int LEFT_W = (IDX_W > DISC_W) ? IDX_W : DISC_W;

   logic [IDX_W-1:0]  pos;
   logic [LEFT_W-1:0] left;
   logic [CH_W-1:0]   ent [DEPTH];
   logic              at_tail;
   logic [IDX_W-1:0]  nxt_pos;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign ent[g] = list[g*CH_W +: CH_W];
   end

   assign at_tail   = (pos >= len_m1);
   assign nxt_pos   = at_tail ? '0 : pos + 1'b1;
   assign chan_o    = ent[pos];
   assign seq_end_o = disc_en ? at_tail : (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o   <= 1'b0;
         active_o <= 1'b0;
         pos      <= '0;
         left     <= '0;
      end else begin
         if (req_i)
            pend_o <= 1'b1;
         else if (begin_i)
            pend_o <= 1'b0;

         if (begin_i) begin
            active_o <= 1'b1;
            if (disc_en) begin
               left <= LEFT_W'(disc_m1);
            end else begin
               pos  <= '0;
               left <= scan_en ? LEFT_W'(len_m1) : '0;
            end
         end else if (done_i) begin
            if (abort_i) begin
               active_o <= 1'b0;
               pos      <= '0;
            end else if (left == '0) begin
               active_o <= 1'b0;
               pos      <= disc_en ? nxt_pos : '0;
            end else begin
               left <= left - 1'b1;
               pos  <= nxt_pos;
            end
         end
      end
   end

   if (PER_RANK) begin : g_slots
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               res_o[s*DATA_W +: DATA_W] <= '0;
            else if (done_i && (pos == IDX_W'(s)))
               res_o[s*DATA_W +: DATA_W] <= res_i;
         end
      end
   end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            res_o <= '0;
         else if (done_i)
            res_o <= res_i;
      end
   end

endmodule

// File: rtl/adc_seq_wdg.sv
module adc_seq_wdg #(
   parameter int CH_W   = 5,
   parameter int DATA_W = 12
) (
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic [DATA_W-1:0] low_i,
   input  logic [DATA_W-1:0] high_i,
   input  logic              single_i,
   input  logic [CH_W-1:0]   sel_i,
   output logic              trip_o
);

   logic watched;
   logic outside;

   assign watched = !single_i || (chan_i == sel_i);
   assign outside = (data_i < low_i) || (data_i > high_i);
   assign trip_o  = valid_i && watched && outside;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CH_W       = 5,
   parameter int DATA_W     = 12,
   parameter int REG_DEPTH  = 16,
   parameter int INJ_DEPTH  = 4,
   parameter int DISC_W     = 3,
   localparam int REG_IDX_W = idx_w(REG_DEPTH),
   localparam int INJ_IDX_W = idx_w(INJ_DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_start,
   input  logic                        inj_start,
   input  logic                        scan_en,
   input  logic                        reg_disc_en,
   input  logic                        inj_disc_en,
   input  logic [DISC_W-1:0]           disc_cnt,
   input  logic                        auto_inj_en,
   input  logic [REG_IDX_W-1:0]        reg_len,
   input  logic [INJ_IDX_W-1:0]        inj_len,
   input  logic [REG_DEPTH*CH_W-1:0]   reg_list,
   input  logic [INJ_DEPTH*CH_W-1:0]   inj_list,
   input  logic                        wdg_single,
   input  logic [CH_W-1:0]             wdg_chan,
   input  logic [DATA_W-1:0]           wdg_low,
   input  logic [DATA_W-1:0]           wdg_high,
   input  logic                        wdg_int_en,
   input  logic                        eoc_int_en,
   input  logic                        jeoc_int_en,
   input  logic                        eoc_clr,
   input  logic                        jeoc_clr,
   input  logic                        wdg_clr,
   output logic                        conv_start,
   output logic [CH_W-1:0]             conv_chan,
   input  logic                        conv_done,
   input  logic [DATA_W-1:0]           conv_data,
   output logic [DATA_W-1:0]           reg_data,
   output logic [INJ_DEPTH*DATA_W-1:0] inj_data,
   output logic                        eoc_flag,
   output logic                        jeoc_flag,
   output logic                        wdg_flag,
   output logic                        eoc_irq,
   output logic                        jeoc_irq,
   output logic                        wdg_irq,
   output logic                        busy
);

   if (REG_DEPTH < 2 || (REG_DEPTH & (REG_DEPTH - 1)) != 0) begin : g_bad_reg_depth
      $error("REG_DEPTH must be a power of two of at least 2");
   end
   if (INJ_DEPTH < 2 || (INJ_DEPTH & (INJ_DEPTH - 1)) != 0) begin : g_bad_inj_depth
      $error("INJ_DEPTH must be a power of two of at least 2");
   end
   if (CH_W < 1 || DATA_W < 2 || DISC_W < 1) begin : g_bad_width
      $error("CH_W, DATA_W and DISC_W are too narrow");
   end

   logic            in_flight;
   grp_e            cur_grp;
   logic            start_q;
   logic [CH_W-1:0] chan_q;

   logic            reg_pend, reg_act, reg_seq_end;
   logic            inj_pend, inj_act, inj_seq_end;
   logic [CH_W-1:0] reg_chan, inj_chan;

   logic            done_ok, reg_done, inj_done;
   logic            trip, abort;
   logic            reg_begin, inj_begin, issue_reg, issue_inj;
   logic            eoc_set, jeoc_set, inj_req;

   assign done_ok  = conv_done && in_flight;
   assign reg_done = done_ok && (cur_grp == GRP_REG);
   assign inj_done = done_ok && (cur_grp == GRP_INJ);
   assign abort    = trip && wdg_int_en;

   assign inj_begin = !in_flight && !inj_act && inj_pend;
   assign issue_inj = !in_flight && inj_act;
   assign reg_begin = !in_flight && !inj_act && !inj_pend && !reg_act && reg_pend;
   assign issue_reg = !in_flight && !inj_act && !inj_pend && reg_act;

   assign eoc_set  = reg_done && reg_seq_end && !abort;
   assign jeoc_set = inj_done && inj_seq_end && !abort;
   assign inj_req  = inj_start || (auto_inj_en && eoc_set);

   adc_seq_group #(
      .DEPTH(REG_DEPTH), .CH_W(CH_W), .DATA_W(DATA_W), .DISC_W(DISC_W), .PER_RANK(1'b0)
   ) u_reg_grp (
      .clk(clk), .rst_n(rst_n), .list(reg_list), .len_m1(reg_len),
      .scan_en(scan_en), .disc_en(reg_disc_en), .disc_m1(disc_cnt),
      .req_i(reg_start), .begin_i(reg_begin), .done_i(reg_done), .abort_i(abort),
      .res_i(conv_data), .pend_o(reg_pend), .active_o(reg_act), .chan_o(reg_chan),
      .seq_end_o(reg_seq_end), .res_o(reg_data)
   );

   adc_seq_group #(
      .DEPTH(INJ_DEPTH), .CH_W(CH_W), .DATA_W(DATA_W), .DISC_W(DISC_W), .PER_RANK(1'b1)
   ) u_inj_grp (
      .clk(clk), .rst_n(rst_n), .list(inj_list), .len_m1(inj_len),
      .scan_en(scan_en), .disc_en(inj_disc_en), .disc_m1('0),
      .req_i(inj_req), .begin_i(inj_begin), .done_i(inj_done), .abort_i(abort),
      .res_i(conv_data), .pend_o(inj_pend), .active_o(inj_act), .chan_o(inj_chan),
      .seq_end_o(inj_seq_end), .res_o(inj_data)
   );

   adc_seq_wdg #(.CH_W(CH_W), .DATA_W(DATA_W)) u_wdg (
      .valid_i(done_ok), .data_i(conv_data), .chan_i(chan_q),
      .low_i(wdg_low), .high_i(wdg_high), .single_i(wdg_single),
      .sel_i(wdg_chan), .trip_o(trip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_flight <= 1'b0;
         cur_grp   <= GRP_REG;
         start_q   <= 1'b0;
         chan_q    <= '0;
      end else begin
         start_q <= 1'b0;
         if (done_ok)
            in_flight <= 1'b0;
         if (issue_inj || issue_reg) begin
            in_flight <= 1'b1;
            start_q   <= 1'b1;
            cur_grp   <= issue_inj ? GRP_INJ : GRP_REG;
            chan_q    <= issue_inj ? inj_chan : reg_chan;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_flag  <= 1'b0;
         jeoc_flag <= 1'b0;
         wdg_flag  <= 1'b0;
      end else begin
         if (eoc_set)       eoc_flag  <= 1'b1;
         else if (eoc_clr)  eoc_flag  <= 1'b0;
         if (jeoc_set)      jeoc_flag <= 1'b1;
         else if (jeoc_clr) jeoc_flag <= 1'b0;
         if (trip)          wdg_flag  <= 1'b1;
         else if (wdg_clr)  wdg_flag  <= 1'b0;
      end
   end

   assign conv_start = start_q;
   assign conv_chan  = chan_q;
   assign eoc_irq    = eoc_flag && eoc_int_en;
   assign jeoc_irq   = jeoc_flag && jeoc_int_en;
   assign wdg_irq    = wdg_flag && wdg_int_en;
   assign busy       = in_flight || reg_act || inj_act || reg_pend || inj_pend;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int CH_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start,
   input logic            conv_done,
   input logic [CH_W-1:0] conv_chan,
   input logic            in_flight,
   input logic            abort,
   input logic            eoc_flag,
   input logic            wdg_flag,
   input logic            eoc_clr,
   input logic            wdg_clr
);

   // R14
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R14
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flight && !conv_done) |=> $stable(conv_chan));

   // R4
   eoc_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_flag) |-> $past(conv_done));

   // R10
   wdg_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdg_flag) |-> $past(conv_done));

   // R12
   eoc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_flag && !eoc_clr) |=> eoc_flag);

   // R12
   wdg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdg_flag && !wdg_clr) |=> wdg_flag);

   // R11
   abort_no_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !eoc_flag) |=> !eoc_flag);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
   .conv_chan(conv_chan), .in_flight(in_flight), .abort(abort),
   .eoc_flag(eoc_flag), .wdg_flag(wdg_flag), .eoc_clr(eoc_clr), .wdg_clr(wdg_clr)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        reg_start = 0, inj_start = 0, scan_en = 0;
   logic        reg_disc_en = 0, inj_disc_en = 0, auto_inj_en = 0;
   logic [2:0]  disc_cnt = 0;
   logic [3:0]  reg_len = 0;
   logic [1:0]  inj_len = 0;
   logic [79:0] reg_list = '0;
   logic [19:0] inj_list = '0;
   logic        wdg_single = 0, wdg_int_en = 0, eoc_int_en = 0, jeoc_int_en = 0;
   logic [4:0]  wdg_chan = 0;
   logic [11:0] wdg_low = 12'h000, wdg_high = 12'hFFF;
   logic        eoc_clr = 0, jeoc_clr = 0, wdg_clr = 0;
   logic        conv_start, conv_done;
   logic [4:0]  conv_chan;
   logic [11:0] conv_data, reg_data;
   logic [47:0] inj_data;
   logic        eoc_flag, jeoc_flag, wdg_flag, eoc_irq, jeoc_irq, wdg_irq, busy;

   adc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_start(reg_start), .inj_start(inj_start),
      .scan_en(scan_en), .reg_disc_en(reg_disc_en), .inj_disc_en(inj_disc_en),
      .disc_cnt(disc_cnt), .auto_inj_en(auto_inj_en), .reg_len(reg_len),
      .inj_len(inj_len), .reg_list(reg_list), .inj_list(inj_list),
      .wdg_single(wdg_single), .wdg_chan(wdg_chan), .wdg_low(wdg_low),
      .wdg_high(wdg_high), .wdg_int_en(wdg_int_en), .eoc_int_en(eoc_int_en),
      .jeoc_int_en(jeoc_int_en), .eoc_clr(eoc_clr), .jeoc_clr(jeoc_clr),
      .wdg_clr(wdg_clr), .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_data(conv_data), .reg_data(reg_data),
      .inj_data(inj_data), .eoc_flag(eoc_flag), .jeoc_flag(jeoc_flag),
      .wdg_flag(wdg_flag), .eoc_irq(eoc_irq), .jeoc_irq(jeoc_irq),
      .wdg_irq(wdg_irq), .busy(busy)
   );

   int   checks = 0, errors = 0;
   bit   finished = 0;
   logic [4:0] rec [64];
   bit   eoc_at [64];
   int   rcnt = 0, ovl = 0, salt = 0;

   function automatic logic [11:0] dfun(input logic [4:0] ch);
      return 12'(int'(ch) * 100 + salt);
   endfunction

   function automatic logic [4:0] rl(input int k);
      return reg_list[k*5 +: 5];
   endfunction

   function automatic logic [4:0] il(input int k);
      return inj_list[k*5 +: 5];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // converter model: fixed latency, records issued channels
   initial begin
      int lat;
      logic [4:0] pc;
      lat = 0; pc = 0;
      conv_done = 0; conv_data = 0;
      forever begin
         @(negedge clk);
         conv_done = 0;
         if (lat > 0) begin
            lat--;
            if (lat == 0) begin
               conv_done = 1;
               conv_data = dfun(pc);
               if (conv_chan !== pc) ovl++;
            end
         end
         if (conv_start === 1'b1) begin
            if (lat != 0) ovl++;
            pc = conv_chan;
            if (rcnt < 64) begin
               rec[rcnt]    = conv_chan;
               eoc_at[rcnt] = eoc_flag;
            end
            rcnt++;
            lat = 3;
         end
      end
   end

   task automatic pulse_reg();
      @(negedge clk); reg_start = 1;
      @(negedge clk); reg_start = 0;
   endtask

   task automatic pulse_inj();
      @(negedge clk); inj_start = 1;
      @(negedge clk); inj_start = 0;
   endtask

   task automatic clear_all();
      @(negedge clk); eoc_clr = 1; jeoc_clr = 1; wdg_clr = 1;
      @(negedge clk); eoc_clr = 0; jeoc_clr = 0; wdg_clr = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk); @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_reg();
      rcnt = 0; pulse_reg(); wait_idle();
   endtask

   task automatic run_inj();
      rcnt = 0; pulse_inj(); wait_idle();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired before the bench completed");
         summary();
         $finish;
      end
   end

   initial begin
      bit ok;
      int len;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(conv_start == 0 && busy == 0, "R1 start/busy after reset", {conv_start, busy}, 0);
      chk({eoc_flag, jeoc_flag, wdg_flag} == 0, "R1 flags after reset",
          {eoc_flag, jeoc_flag, wdg_flag}, 0);
      chk({eoc_irq, jeoc_irq, wdg_irq} == 0, "R1 irqs after reset",
          {eoc_irq, jeoc_irq, wdg_irq}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2 single conversion of entry 0
      for (int k = 0; k < 16; k++) reg_list[k*5 +: 5] = 5'(k + 3);
      reg_len = 4'd5; scan_en = 0; eoc_int_en = 1; salt = 7;
      run_reg();
      chk(rcnt == 1 && rec[0] == rl(0), "R2 single count/channel", rcnt, 1);
      chk(reg_data == dfun(rl(0)), "R6 single result", reg_data, dfun(rl(0)));
      chk(eoc_flag == 1 && eoc_irq == 1, "R5 eoc irq with enable", eoc_irq, 1);
      eoc_int_en = 0; @(negedge clk);
      chk(eoc_irq == 0 && eoc_flag == 1, "R5 eoc irq without enable", eoc_irq, 0);

      // R3 R4 random scans
      scan_en = 1;
      for (int it = 0; it < 12; it++) begin
         clear_all();
         len = (it == 0) ? 1 : (it == 1) ? 16 : $urandom_range(1, 16);
         reg_len = 4'(len - 1);
         for (int k = 0; k < 16; k++) reg_list[k*5 +: 5] = 5'($urandom_range(0, 31));
         salt = $urandom_range(0, 99);
         run_reg();
         ok = (rcnt == len);
         for (int k = 0; k < len && k < 64; k++) if (rec[k] != rl(k)) ok = 0;
         chk(ok, "R3 scan order", rcnt, len);
         ok = 1;
         for (int k = 1; k < len; k++) if (eoc_at[k]) ok = 0;
         chk(ok, "R4 no eoc before last entry", 1, 0);
         chk(eoc_flag == 1, "R4 eoc after last entry", eoc_flag, 1);
         chk(reg_data == dfun(rl(len - 1)), "R6 regular result", reg_data, dfun(rl(len - 1)));
         chk(wdg_flag == 0, "R10 full window no trip", wdg_flag, 0);
      end

      // injected scan, slots by entry
      clear_all();
      inj_list = {5'd29, 5'd17, 5'd8, 5'd1}; inj_len = 2'd3; jeoc_int_en = 1; salt = 3;
      run_inj();
      ok = (rcnt == 4);
      for (int k = 0; k < 4; k++) if (rec[k] != il(k)) ok = 0;
      chk(ok, "R3 injected scan order", rcnt, 4);
      for (int k = 0; k < 4; k++)
         chk(inj_data[k*12 +: 12] == dfun(il(k)), "R6 injected slot",
             inj_data[k*12 +: 12], dfun(il(k)));
      chk(jeoc_flag == 1 && jeoc_irq == 1 && eoc_flag == 0, "R4 jeoc only", jeoc_flag, 1);
      clear_all(); scan_en = 0;
      run_inj();
      chk(rcnt == 1 && rec[0] == il(0), "R2 injected single entry", rcnt, 1);
      chk(jeoc_flag == 1, "R4 jeoc single", jeoc_flag, 1);

      // R7 automatic chaining
      clear_all(); scan_en = 1; auto_inj_en = 1; reg_len = 4'd2; inj_len = 2'd1;
      run_reg();
      ok = (rcnt == 5) && rec[0] == rl(0) && rec[1] == rl(1) && rec[2] == rl(2)
           && rec[3] == il(0) && rec[4] == il(1);
      chk(ok, "R7 injected list chained after regular", rcnt, 5);
      chk(eoc_flag && jeoc_flag, "R7 both end flags", {eoc_flag, jeoc_flag}, 3);
      auto_inj_en = 0;

      // R8 regular discontinuous, burst 3, list of 7
      clear_all(); reg_disc_en = 1; disc_cnt = 3'd2; reg_len = 4'd6;
      for (int k = 0; k < 16; k++) reg_list[k*5 +: 5] = 5'(k + 10);
      run_reg();
      chk(rcnt == 3 && rec[0] == rl(0) && rec[2] == rl(2), "R8 first burst", rcnt, 3);
      chk(eoc_flag == 0, "R8 no eoc mid list", eoc_flag, 0);
      run_reg();
      chk(rcnt == 3 && rec[0] == rl(3) && rec[2] == rl(5), "R8 second burst", rec[0], rl(3));
      run_reg();
      chk(rcnt == 3 && rec[0] == rl(6) && rec[1] == rl(0) && rec[2] == rl(1),
          "R8 wrapping burst", rec[1], rl(0));
      chk(eoc_flag == 1, "R8 eoc at last entry", eoc_flag, 1);
      reg_disc_en = 0;

      // R9 injected discontinuous, regular unaffected
      clear_all(); inj_disc_en = 1; inj_len = 2'd2; inj_list = {5'd0, 5'd21, 5'd14, 5'd6};
      for (int r = 0; r < 3; r++) begin
         run_inj();
         chk(rcnt == 1 && rec[0] == il(r), "R9 one injected entry per request", rec[0], il(r));
         chk(jeoc_flag == (r == 2), "R9 jeoc at last injected entry", jeoc_flag, (r == 2));
      end
      run_reg();
      chk(rcnt == 7, "R9 regular list still full scan", rcnt, 7);
      inj_disc_en = 0;

      // R10 R11 watchdog without abort
      clear_all(); salt = 0; wdg_low = 12'd500; wdg_high = 12'd1500; wdg_int_en = 0;
      reg_len = 4'd4;
      reg_list[24:0] = {5'd13, 5'd12, 5'd3, 5'd11, 5'd10};
      run_reg();
      chk(wdg_flag == 1 && wdg_irq == 0, "R10 trip below low", wdg_flag, 1);
      chk(rcnt == 5 && eoc_flag == 1, "R11 no abort when disabled", rcnt, 5);

      // R11 abort
      clear_all(); wdg_int_en = 1;
      run_reg();
      chk(rcnt == 3, "R11 scan aborted at trip", rcnt, 3);
      chk(eoc_flag == 0 && wdg_flag == 1 && wdg_irq == 1, "R11 no eoc after abort",
          eoc_flag, 0);

      // R10 single-channel watchdog
      clear_all(); wdg_int_en = 0; wdg_single = 1; wdg_chan = 5'd10;
      reg_list[24:0] = {5'd13, 5'd12, 5'd20, 5'd11, 5'd10};
      run_reg();
      chk(wdg_flag == 0, "R10 other channel ignored", wdg_flag, 0);
      wdg_chan = 5'd20;
      run_reg();
      chk(wdg_flag == 1, "R10 watched channel above high", wdg_flag, 1);
      wdg_single = 0; wdg_low = 0; wdg_high = 12'hFFF;

      // R13 repeat request while busy
      clear_all(); reg_len = 4'd3;
      reg_list[19:0] = {5'd4, 5'd3, 5'd2, 5'd1};
      rcnt = 0; pulse_reg(); repeat (3) @(negedge clk); pulse_reg(); wait_idle();
      ok = (rcnt == 8);
      for (int k = 0; k < 8; k++) if (rec[k] != 5'((k % 4) + 1)) ok = 0;
      chk(ok, "R13 second request served", rcnt, 8);

      // R13 injected request during regular scan
      clear_all(); reg_len = 4'd5; scan_en = 1;
      reg_list[29:0] = {5'd6, 5'd5, 5'd4, 5'd3, 5'd2, 5'd1};
      inj_len = 2'd0; inj_list[4:0] = 5'd25;
      rcnt = 0; pulse_reg(); repeat (6) @(negedge clk); pulse_inj(); wait_idle();
      begin
         int pos_i, nr;
         pos_i = -1; nr = 0; ok = (rcnt == 7);
         for (int k = 0; k < 7; k++) begin
            if (rec[k] == 5'd25) pos_i = k;
            else begin
               if (rec[k] != 5'(nr + 1)) ok = 0;
               nr++;
            end
         end
         chk(ok, "R13 regular order kept around injected entry", rcnt, 7);
         chk(pos_i > 0 && pos_i < 6, "R13 injected served mid scan", pos_i, 1);
      end
      chk(eoc_flag && jeoc_flag, "R13 both flags", {eoc_flag, jeoc_flag}, 3);

      // R12 flags held, clears independent
      repeat (20) @(negedge clk);
      chk(eoc_flag && jeoc_flag, "R12 flags held while idle", {eoc_flag, jeoc_flag}, 3);
      @(negedge clk); eoc_clr = 1; @(negedge clk); eoc_clr = 0; @(negedge clk);
      chk(eoc_flag == 0 && jeoc_flag == 1, "R12 eoc clear only", {eoc_flag, jeoc_flag}, 1);
      @(negedge clk); jeoc_clr = 1; @(negedge clk); jeoc_clr = 0; @(negedge clk);
      chk(jeoc_flag == 0, "R12 jeoc clear", jeoc_flag, 0);

      // R14 handshake discipline over the whole run
      chk(ovl == 0, "R14 overlap or channel change", ovl, 0);

      finished = 1;
      summary();
      $finish;
   end

endmodule